// File: doc/BRIEF.md
# Codec Power-Up Sequencing Controller

This block enforces the startup order inside a mixed-signal codec. A hardware reset or a software reset command returns every setting to its default. An initialization window follows each reset. During that window, coefficient-buffer accesses are rejected and flagged, and every block power-up request is refused. After the window closes, analog blocks can be brought up: the PLL, the left and right playback converters, and the analog bypass path. A shared reference must be settled before any of them turns on. The reference starts by itself when a block asks for power, or it can be enabled on its own.

Power-up requests that arrive while the reference settles wait in a small queue. The queue holds one flag per block. It releases one block per cycle in a fixed priority once the reference is ready. When the PLL is switched on, a settle timer runs before the block reports that clocks are available. All delays are parameters given in clock cycles: INIT_CYCLES, REF_CYCLES and PLL_CYCLES.

Configuration writes use a valid/ready port. A write is taken on a rising edge where `cfg_valid` and `cfg_ready` are both high. `cfg_ready` drops while an internal reset is in effect. The sender must then hold page, address and data stable until the write is taken. Block indices are 0 = PLL, 1 = left converter, 2 = right converter, 3 = bypass.

Top module: `codec_pwrseq_ctrl`

## Requirements
- R1: Taking `hw_rst_n` low forces all state to defaults at the next clock edge. The reset is released through a two-stage synchronizer, so internal reset ends on the second rising edge after `hw_rst_n` goes high.
- R2: A write accepted with page 0, address 1 and data bit 0 set acts as a full reset. The reset takes effect one edge after the write is taken. Writes to any other page or address, or with bit 0 clear, do not reset.
- R3: After any reset, the common-mode select `cm_sel` reads 0 (0.75 V). A write to page 1, address 10 loads `cm_sel` from data bit 6 (1 = 0.9 V). Writes elsewhere leave it unchanged.
- R4: `init_busy` is high during internal reset and for INIT_CYCLES edges after it ends. Once low, it stays low until the next reset.
- R5: A `buf_req` sampled while `init_busy` is high produces a one-cycle `buf_err` pulse on the following edge. A `buf_req` outside that window never raises `buf_err`.
- R6: Power-up requests and `ref_en` seen while `init_busy` is high are dropped. Nothing is powered during that window.
- R7: No bit of `powered` is ever high unless `ref_ready` is high.
- R8: The reference leaves the off state on the first edge after initialization where `ref_en`, a pending request or a powered block needs it. It then takes REF_CYCLES more edges to report ready. It turns off on the first edge where it is ready and nothing needs it.
- R9: A request sets that block's pending flag unless the block is already powered. A repeat request merges with the existing flag. While the reference is ready, one pending block per edge is powered, lowest index first, so the PLL goes first.
- R10: `clk_available` rises PLL_CYCLES edges after the edge that powers the PLL.
- R11: A power-down pulse clears that block's `powered` and pending bits on the next edge. A PLL power-down also drops `clk_available` on that same edge and cancels any settle in progress. A power-down wins over a simultaneous power-up.
- R12: `cfg_ready` is low whenever an internal reset is in effect, including the cycle after a software reset write is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| hw_rst_n | input | 1 | Active-low hardware reset, asynchronous assert |
| cfg_valid | input | 1 | Configuration write valid |
| cfg_ready | output | 1 | Configuration write ready |
| cfg_page | input | 8 | Page of the write |
| cfg_addr | input | 7 | Register address within the page |
| cfg_wdata | input | 8 | Write data |
| ref_en | input | 1 | Standalone reference enable (level) |
| pwr_up | input | 4 | Per-block power-up request pulses |
| pwr_dn | input | 4 | Per-block power-down pulses |
| buf_req | input | 1 | Coefficient-buffer access attempt |
| init_busy | output | 1 | Initialization lockout in progress |
| ref_ready | output | 1 | Shared reference settled |
| powered | output | 4 | Per-block powered state |
| clk_available | output | 1 | PLL settled, clocks usable |
| buf_err | output | 1 | Rejected buffer access pulse |
| cm_sel | output | 1 | Common-mode select, 0 = 0.75 V, 1 = 0.9 V |

## Verification
A bad lockout count moves the falling edge of `init_busy` away from INIT_CYCLES. It also lets a buffer access pass without `buf_err`, and both show within one cycle of the expected edge. A corrupted pending flag or priority decoder shows up in the next cycle: `powered` then gains bits out of order, gains two bits in one edge, or gains a bit before `ref_ready`. A wrong PLL or reference counter moves `clk_available` or `ref_ready` by whole cycles. A missed cancel leaves `clk_available` rising after a PLL power-down, which is visible PLL_CYCLES edges later.

// File: rtl/codec_pwrseq_pkg.sv
`timescale 1ns/1ps
package codec_pwrseq_pkg;
  localparam int NUM_BLK = 4;
  localparam int BLK_PLL = 0;

  typedef enum logic [1:0] {
    REF_OFF    = 2'd0,
    REF_SETTLE = 2'd1,
    REF_READY  = 2'd2
  } ref_state_e;

  localparam logic [7:0] PG_CTRL   = 8'd0;
  localparam logic [7:0] PG_ANALOG = 8'd1;
  localparam logic [6:0] RA_SWRST  = 7'd1;
  localparam logic [6:0] RA_CMODE  = 7'd10;
  localparam int         SWRST_BIT = 0;
  localparam int         CM_BIT    = 6;
endpackage

// File: rtl/pwrseq_reset_ctl.sv
`timescale 1ns/1ps
module pwrseq_reset_ctl #(
  parameter int INIT_CYCLES = 100000
) (
  input  logic clk,
  input  logic hw_rst_n,
  input  logic soft_req,
  output logic core_rst,
  output logic init_busy
);
  localparam int IW = $clog2(INIT_CYCLES + 1);

  logic [1:0]    sync_q;
  logic          soft_fire;
  logic [IW-1:0] init_cnt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk) begin
    if (!sync_q[1]) soft_fire <= 1'b0;
    else            soft_fire <= soft_req;
  end

  assign core_rst = ~sync_q[1] | soft_fire;

  always_ff @(posedge clk) begin
    if (core_rst)            init_cnt <= IW'(INIT_CYCLES);
    else if (init_cnt != '0) init_cnt <= init_cnt - IW'(1);
  end

  assign init_busy = core_rst | (init_cnt != '0);

  a_r4_lockout_stays_open: assert property (@(posedge clk) disable iff (core_rst)
    !init_busy |=> !init_busy);
  a_r4_lockout_after_reset: assert property (@(posedge clk) disable iff (core_rst)
    $fell(core_rst) |-> init_busy);
endmodule

// File: rtl/pwrseq_cfg_regs.sv
`timescale 1ns/1ps
module pwrseq_cfg_regs
  import codec_pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       core_rst,
  input  logic       cfg_valid,
  output logic       cfg_ready,
  input  logic [7:0] cfg_page,
  input  logic [6:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic       soft_req,
  output logic       cm_sel
);
  logic accept;
  logic unused_wdata;

  assign cfg_ready = ~core_rst;
  assign accept    = cfg_valid & cfg_ready;

  assign soft_req = accept && (cfg_page == PG_CTRL) && (cfg_addr == RA_SWRST)
                    && cfg_wdata[SWRST_BIT];

  always_ff @(posedge clk) begin
    if (core_rst) cm_sel <= 1'b0;
    else if (accept && (cfg_page == PG_ANALOG) && (cfg_addr == RA_CMODE))
      cm_sel <= cfg_wdata[CM_BIT];
  end

  assign unused_wdata = ^cfg_wdata;

  a_r12_no_accept_in_reset: assert property (@(posedge clk)
    core_rst |-> !soft_req);
endmodule

// File: rtl/pwrseq_ref_ctl.sv
`timescale 1ns/1ps
module pwrseq_ref_ctl
  import codec_pwrseq_pkg::*;
#(
  parameter int REF_CYCLES = 40000
) (
  input  logic clk,
  input  logic core_rst,
  input  logic init_busy,
  input  logic ref_en,
  input  logic blk_need,
  output logic ref_ready
);
  localparam int RW = $clog2(REF_CYCLES + 1);

  ref_state_e    state;
  logic [RW-1:0] cnt;
  logic          need;

  assign need = ref_en | blk_need;

  always_ff @(posedge clk) begin
    if (core_rst) begin
      state <= REF_OFF;
      cnt   <= '0;
    end else begin
      unique case (state)
        REF_OFF: if (need && !init_busy) begin
          state <= REF_SETTLE;
          cnt   <= RW'(REF_CYCLES - 1);
        end
        REF_SETTLE: if (cnt == '0) state <= REF_READY;
                    else           cnt   <= cnt - RW'(1);
        REF_READY: if (!need) state <= REF_OFF;
        default: state <= REF_OFF;
      endcase
    end
  end

  assign ref_ready = (state == REF_READY);

  a_r6_ref_idle_in_lockout: assert property (@(posedge clk) disable iff (core_rst)
    init_busy |-> state == REF_OFF);
  a_r8_ready_via_settle: assert property (@(posedge clk) disable iff (core_rst)
    $rose(ref_ready) |-> $past(state) == REF_SETTLE);
endmodule

// File: rtl/pwrseq_req_queue.sv
`timescale 1ns/1ps
module pwrseq_req_queue
  import codec_pwrseq_pkg::*;
(
  input  logic               clk,
  input  logic               core_rst,
  input  logic               init_busy,
  input  logic               ref_ready,
  input  logic [NUM_BLK-1:0] up,
  input  logic [NUM_BLK-1:0] dn,
  output logic [NUM_BLK-1:0] pending,
  output logic [NUM_BLK-1:0] powered,
  output logic               pll_start,
  output logic               pll_stop
);
  logic [NUM_BLK-1:0] grant;

  // lowest index wins; one grant per edge
  always_comb begin
    logic found;
    grant = '0;
    found = 1'b0;
    if (ref_ready) begin
      for (int i = 0; i < NUM_BLK; i++) begin
        if (pending[i] && !found) begin
          grant[i] = 1'b1;
          found    = 1'b1;
        end
      end
    end
  end

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    always_ff @(posedge clk) begin
      if (core_rst) begin
        pending[b] <= 1'b0;
        powered[b] <= 1'b0;
      end else begin
        if (dn[b]) begin
          pending[b] <= 1'b0;
          powered[b] <= 1'b0;
        end else if (grant[b]) begin
          pending[b] <= 1'b0;
          powered[b] <= 1'b1;
        end else if (up[b] && !init_busy && !powered[b]) begin
          pending[b] <= 1'b1;
        end
      end
    end
  end

  assign pll_start = grant[BLK_PLL] & ~dn[BLK_PLL];
  assign pll_stop  = dn[BLK_PLL];

  a_r7_ref_before_power: assert property (@(posedge clk) disable iff (core_rst)
    (|powered) |-> ref_ready);
  a_r6_nothing_in_lockout: assert property (@(posedge clk) disable iff (core_rst)
    init_busy |-> (powered == '0) && (pending == '0));
  a_r9_one_per_edge: assert property (@(posedge clk) disable iff (core_rst)
    $countones(powered & ~$past(powered)) <= 1);
endmodule

// File: rtl/pwrseq_pll_timer.sv
`timescale 1ns/1ps
module pwrseq_pll_timer #(
  parameter int PLL_CYCLES = 1000000
) (
  input  logic clk,
  input  logic core_rst,
  input  logic start,
  input  logic stop,
  input  logic pll_on,
  output logic clk_available
);
  localparam int PW = $clog2(PLL_CYCLES + 1);

  logic          run;
  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (core_rst || stop) begin
      run           <= 1'b0;
      cnt           <= '0;
      clk_available <= 1'b0;
    end else if (start) begin
      run           <= 1'b1;
      cnt           <= PW'(PLL_CYCLES - 1);
      clk_available <= 1'b0;
    end else if (run) begin
      if (cnt == '0) begin
        run           <= 1'b0;
        clk_available <= 1'b1;
      end else begin
        cnt <= cnt - PW'(1);
      end
    end
  end

  a_r11_clk_needs_pll: assert property (@(posedge clk) disable iff (core_rst)
    !pll_on |-> !clk_available);
  a_r10_clk_after_pll: assert property (@(posedge clk) disable iff (core_rst)
    $rose(clk_available) |-> pll_on && $past(pll_on));
endmodule

// File: rtl/codec_pwrseq_ctrl.sv
`timescale 1ns/1ps
module codec_pwrseq_ctrl
  import codec_pwrseq_pkg::*;
#(
  parameter int INIT_CYCLES = 100000,
  parameter int REF_CYCLES  = 40000,
  parameter int PLL_CYCLES  = 1000000
) (
  input  logic       clk,
  input  logic       hw_rst_n,
  input  logic       cfg_valid,
  output logic       cfg_ready,
  input  logic [7:0] cfg_page,
  input  logic [6:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic       ref_en,
  input  logic [3:0] pwr_up,
  input  logic [3:0] pwr_dn,
  input  logic       buf_req,
  output logic       init_busy,
  output logic       ref_ready,
  output logic [3:0] powered,
  output logic       clk_available,
  output logic       buf_err,
  output logic       cm_sel
);
  logic               core_rst;
  logic               soft_req;
  logic [NUM_BLK-1:0] pending;
  logic               pll_start;
  logic               pll_stop;

  pwrseq_reset_ctl #(.INIT_CYCLES(INIT_CYCLES)) u_rst (
    .clk(clk), .hw_rst_n(hw_rst_n), .soft_req(soft_req),
    .core_rst(core_rst), .init_busy(init_busy));

  pwrseq_cfg_regs u_cfg (
    .clk(clk), .core_rst(core_rst), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_page(cfg_page), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .soft_req(soft_req), .cm_sel(cm_sel));

  pwrseq_ref_ctl #(.REF_CYCLES(REF_CYCLES)) u_ref (
    .clk(clk), .core_rst(core_rst), .init_busy(init_busy), .ref_en(ref_en),
    .blk_need((|pending) | (|powered)), .ref_ready(ref_ready));

  pwrseq_req_queue u_q (
    .clk(clk), .core_rst(core_rst), .init_busy(init_busy), .ref_ready(ref_ready),
    .up(pwr_up), .dn(pwr_dn), .pending(pending), .powered(powered),
    .pll_start(pll_start), .pll_stop(pll_stop));

  pwrseq_pll_timer #(.PLL_CYCLES(PLL_CYCLES)) u_pll (
    .clk(clk), .core_rst(core_rst), .start(pll_start), .stop(pll_stop),
    .pll_on(powered[BLK_PLL]), .clk_available(clk_available));

  always_ff @(posedge clk) begin
    if (core_rst) buf_err <= 1'b0;
    else          buf_err <= buf_req & init_busy;
  end

  a_r5_err_only_in_lockout: assert property (@(posedge clk) disable iff (core_rst)
    buf_err |-> $past(init_busy) && $past(buf_req));
endmodule

// File: tb/tb_codec_pwrseq_ctrl.sv
`timescale 1ns/1ps
module tb_codec_pwrseq_ctrl;
  localparam int INIT_C = 8;
  localparam int REF_C  = 5;
  localparam int PLL_C  = 10;

  logic       clk = 1'b0;
  logic       hw_rst_n = 1'b0;
  logic       cfg_valid = 1'b0;
  logic       cfg_ready;
  logic [7:0] cfg_page = '0;
  logic [6:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       ref_en = 1'b0;
  logic [3:0] pwr_up = '0;
  logic [3:0] pwr_dn = '0;
  logic       buf_req = 1'b0;
  logic       init_busy, ref_ready, clk_available, buf_err, cm_sel;
  logic [3:0] powered;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  codec_pwrseq_ctrl #(.INIT_CYCLES(INIT_C), .REF_CYCLES(REF_C), .PLL_CYCLES(PLL_C)) dut (
    .clk(clk), .hw_rst_n(hw_rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_page(cfg_page), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ref_en(ref_en), .pwr_up(pwr_up), .pwr_dn(pwr_dn), .buf_req(buf_req),
    .init_busy(init_busy), .ref_ready(ref_ready), .powered(powered),
    .clk_available(clk_available), .buf_err(buf_err), .cm_sel(cm_sel));

  typedef struct packed {
    logic [3:0] up;
    logic [3:0] dn;
    logic       ren;
    logic [7:0] wait_n;
    logic [3:0] e_pow;
    logic       e_ref;
    logic       e_clk;
    logic [3:0] req;
  } row_t;

  // Rows start after the lockout has ended, with the reference off.
  localparam int NROW = 19;
  localparam row_t TBL [NROW] = '{
    '{4'b0001, 4'b0000, 1'b0, 8'd2,  4'b0000, 1'b0, 1'b0, 4'd9},  // R9 queued
    '{4'b0011, 4'b0000, 1'b0, 8'd0,  4'b0000, 1'b0, 1'b0, 4'd7},  // R7 none while settling
    '{4'b0000, 4'b0000, 1'b0, 8'd2,  4'b0000, 1'b1, 1'b0, 4'd8},  // R8 ready after settle
    '{4'b0000, 4'b0000, 1'b0, 8'd0,  4'b0001, 1'b1, 1'b0, 4'd9},  // R9 PLL first
    '{4'b0000, 4'b0000, 1'b0, 8'd0,  4'b0011, 1'b1, 1'b0, 4'd9},  // R9 then left
    '{4'b0000, 4'b0000, 1'b0, 8'd7,  4'b0011, 1'b1, 1'b0, 4'd10}, // R10 not yet
    '{4'b0000, 4'b0000, 1'b0, 8'd0,  4'b0011, 1'b1, 1'b1, 4'd10}, // R10 clocks up
    '{4'b1100, 4'b0000, 1'b0, 8'd0,  4'b0011, 1'b1, 1'b1, 4'd9},
    '{4'b0000, 4'b0000, 1'b0, 8'd0,  4'b0111, 1'b1, 1'b1, 4'd9},
    '{4'b0000, 4'b0000, 1'b0, 8'd0,  4'b1111, 1'b1, 1'b1, 4'd9},
    '{4'b0000, 4'b0001, 1'b0, 8'd0,  4'b1110, 1'b1, 1'b0, 4'd11}, // R11 clk drops
    '{4'b0000, 4'b1110, 1'b0, 8'd0,  4'b0000, 1'b1, 1'b0, 4'd11},
    '{4'b0000, 4'b0000, 1'b0, 8'd0,  4'b0000, 1'b0, 1'b0, 4'd8},  // R8 ref off
    '{4'b0000, 4'b0000, 1'b1, 8'd4,  4'b0000, 1'b0, 1'b0, 4'd8},  // R8 standalone
    '{4'b0000, 4'b0000, 1'b1, 8'd0,  4'b0000, 1'b1, 1'b0, 4'd8},
    '{4'b0001, 4'b0000, 1'b1, 8'd1,  4'b0001, 1'b1, 1'b0, 4'd9},
    '{4'b0000, 4'b0001, 1'b1, 8'd0,  4'b0000, 1'b1, 1'b0, 4'd11}, // R11 cancel
    '{4'b0000, 4'b0000, 1'b1, 8'd12, 4'b0000, 1'b1, 1'b0, 4'd11},
    '{4'b0000, 4'b0000, 1'b0, 8'd0,  4'b0000, 1'b0, 1'b0, 4'd8}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic cfg_write(input logic [7:0] pg, input logic [6:0] ad, input logic [7:0] d);
    cfg_page = pg; cfg_addr = ad; cfg_wdata = d; cfg_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    edges(4);
    // R1 R3 R12 reset state
    check("R1 busy in reset", init_busy, 1);
    check("R1 powered in reset", {powered, ref_ready, clk_available, buf_err}, 0);
    check("R3 cm default", cm_sel, 0);
    check("R12 ready low in reset", cfg_ready, 0);

    hw_rst_n = 1'b1;
    edges(3);
    buf_req = 1'b1; pwr_up = 4'b1111;
    edges(1);
    buf_req = 1'b0; pwr_up = 4'b0000;
    check("R5 error in lockout", buf_err, 1);
    edges(1);
    check("R5 error is one cycle", buf_err, 0);
    edges(4);
    check("R4 busy at 9 edges", init_busy, 1);
    edges(1);
    check("R4 busy clear at 10 edges", init_busy, 0);
    check("R1 R12 ready after release", cfg_ready, 1);
    edges(10);
    check("R6 dropped requests", {powered, ref_ready}, 0);
    buf_req = 1'b1;
    edges(1);
    buf_req = 1'b0;
    check("R5 no error after lockout", buf_err, 0);

    for (int r = 0; r < NROW; r++) begin
      pwr_up = TBL[r].up; pwr_dn = TBL[r].dn; ref_en = TBL[r].ren;
      @(posedge clk);
      @(negedge clk);
      pwr_up = '0; pwr_dn = '0;
      edges(int'(TBL[r].wait_n));
      check($sformatf("R%0d row %0d", TBL[r].req, r),
            {powered, ref_ready, clk_available},
            {TBL[r].e_pow, TBL[r].e_ref, TBL[r].e_clk});
    end
    ref_en = 1'b0;

    cfg_write(8'd1, 7'd10, 8'h40);
    check("R3 cm set", cm_sel, 1);
    cfg_write(8'd1, 7'd11, 8'h00);
    check("R3 other address ignored", cm_sel, 1);
    cfg_write(8'd0, 7'd1, 8'h02);
    edges(1);
    check("R2 bit0 clear no reset", {init_busy, cm_sel}, 2'b01);
    cfg_write(8'd1, 7'd1, 8'h01);
    edges(1);
    check("R2 wrong page no reset", {init_busy, cm_sel}, 2'b01);

    pwr_up = 4'b0010;
    edges(1);
    pwr_up = '0;
    edges(9);
    check("R9 left powered", powered, 4'b0010);

    cfg_write(8'd0, 7'd1, 8'h01);
    check("R12 ready low after soft reset", cfg_ready, 0);
    edges(1);
    check("R2 soft reset state", {init_busy, powered, ref_ready, cm_sel}, 7'b1000000);
    edges(7);
    check("R4 busy after soft reset", init_busy, 1);
    edges(1);
    check("R4 lockout ends after soft reset", init_busy, 0);

    pwr_up = 4'b0010;
    edges(1);
    pwr_up = '0;
    edges(9);
    cfg_write(8'd1, 7'd10, 8'h40);
    check("R9 powered again", {powered, cm_sel}, 5'b00101);
    hw_rst_n = 1'b0;
    edges(1);
    check("R1 async reset clears", {init_busy, powered, ref_ready, cm_sel}, 7'b1000000);
    hw_rst_n = 1'b1;
    edges(12);
    check("R1 release again", init_busy, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule